// File: doc/BRIEF.md
# Endian-Aware Host Bus Slave

This block is a 32-bit asynchronous, SRAM-style slave port. It connects an external processor to a small internal register space and to two packet data FIFOs. The chip-select, read strobe and write strobe arrive with no timing relation to the internal clock. They are brought into the clock domain through a flop synchronizer before any access takes effect. Everything inside the block is little-endian. Bytes are reordered only at the host boundary, and the order is chosen separately for each access by an endian-select input.

A FIFO-select input overrides the address decode. While it is high, every write lands in the transmit data FIFO and every read takes a word from the receive data FIFO, whatever the address. Host DMA engines that can only walk incrementing addresses can therefore stream packet data. The internal side pushes received words into the receive FIFO and pops the transmit FIFO. Three sticky event bits are combined with a per-bit enable to drive a single registered interrupt line.

Top module: `hostport_bridge`

## Requirements
- R1: After reset the read-data output is zero with its enable low, the interrupt is low, both FIFOs are empty, and the level, status, enable and scratch words read as zero.
- R2: A write takes effect exactly once, after the synchronized end of the access (chip-select or write strobe released). A single write to the transmit window raises the transmit count by exactly one.
- R3: The read-data enable is high, and the read-data output non-zero, only after chip-select and the read strobe have both been seen asserted through the synchronizer. The output returns to zero with the enable low once the strobe is released.
- R4: With endian-select low, write data is stored and read data is returned with no byte reordering.
- R5: With endian-select high, the four bytes of the word are reversed on writes and on reads. The order is sampled per access, so a word written in one order and read in the other comes back byte-reversed.
- R6: Byte offsets when FIFO-select is low: 0x00 is the transmit data window (write), 0x04 the receive data window (read), 0x08 the level word (transmit count in bits 15:8, receive count in bits 7:0), 0x0C the event status, 0x10 the event enable (bits 2:0) and 0x14 a 32-bit scratch word. A misaligned or unmapped address reads zero and ignores writes.
- R7: With FIFO-select high, any write address pushes into the transmit FIFO and leaves the register at that address unchanged. Any read address pops the receive FIFO.
- R8: Each completed read of the receive FIFO returns the oldest word and removes exactly one word.
- R9: A write to a full transmit FIFO is dropped and sets status bit 0.
- R10: A read of an empty receive FIFO returns zero and sets status bit 1.
- R11: A word accepted into the receive FIFO from the internal side sets status bit 2. Writing a one to a status bit clears it, and writing a zero leaves it alone.
- R12: The interrupt output is high one cycle after any status bit is set while its enable bit is set, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hcs_n | input | 1 | Host chip-select, active low, asynchronous |
| hrd_n | input | 1 | Host read strobe, active low, asynchronous |
| hwr_n | input | 1 | Host write strobe, active low, asynchronous |
| haddr | input | ADDR_W | Host byte address |
| hwdata | input | 32 | Host write data |
| hbig_end | input | 1 | Endian select for the current access: 1 reverses bytes |
| hfifo_sel | input | 1 | Steers the access to the data FIFOs whatever the address |
| hrdata | output | 32 | Host read data, zero when not driving |
| hrd_oe | output | 1 | Read data enable |
| irq | output | 1 | Interrupt request, active high |
| rx_push | input | 1 | Internal side pushes one word into the receive FIFO |
| rx_wdata | input | 32 | Word pushed into the receive FIFO |
| rx_full | output | 1 | Receive FIFO is full |
| tx_pop | input | 1 | Internal side removes one word from the transmit FIFO |
| tx_rdata | output | 32 | Oldest word in the transmit FIFO |
| tx_empty | output | 1 | Transmit FIFO is empty |

## Verification
The assertions check on every cycle that a write commit never repeats in the next cycle, that the read enable only follows a synchronized active read, that an overflow event always lands in the sticky status, that the FIFO counts stay within bounds and do not move on a dropped push, that a pop removes exactly one word, and that the interrupt only rises when some enable is set. Only the bench's scenarios can show the byte order of stored and returned data for each combination of write and read endian settings, the address map, the steering of arbitrary addresses by FIFO-select, the first-in first-out order across both windows, and the write-one-to-clear behaviour seen through the host port.

// File: rtl/hp_pkg.sv
package hp_pkg;
  localparam int unsigned BUS_W   = 32;
  localparam int unsigned BYTES   = BUS_W / 8;
  localparam int unsigned NEVT    = 3;

  localparam logic [31:0] OFS_TXWIN = 32'h00;
  localparam logic [31:0] OFS_RXWIN = 32'h04;
  localparam logic [31:0] OFS_LEVEL = 32'h08;
  localparam logic [31:0] OFS_EVSTS = 32'h0C;
  localparam logic [31:0] OFS_EVEN  = 32'h10;
  localparam logic [31:0] OFS_SCR   = 32'h14;

  typedef enum logic [2:0] {
    TGT_NONE, TGT_TX, TGT_RX, TGT_LVL, TGT_STS, TGT_EN, TGT_SCR
  } tgt_e;

  function automatic tgt_e map_addr(input logic [31:0] a);
    tgt_e t;
    t = TGT_NONE;
    if (a[1:0] == 2'b00) begin
      case (a)
        OFS_TXWIN: t = TGT_TX;
        OFS_RXWIN: t = TGT_RX;
        OFS_LEVEL: t = TGT_LVL;
        OFS_EVSTS: t = TGT_STS;
        OFS_EVEN:  t = TGT_EN;
        OFS_SCR:   t = TGT_SCR;
        default:   t = TGT_NONE;
      endcase
    end
    return t;
  endfunction
endpackage

// File: rtl/hp_sync.sv
module hp_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stg_q [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) stg_q[0] <= '0;
          else        stg_q[0] <= din;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) stg_q[s] <= '0;
          else        stg_q[s] <= stg_q[s-1];
      end
    end
  endgenerate

  assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/hp_swap.sv
module hp_swap #(
  parameter int unsigned NBYTES = 4
) (
  input  logic                  rev,
  input  logic [8*NBYTES-1:0]   din,
  output logic [8*NBYTES-1:0]   dout
);
  genvar b;
  generate
    for (b = 0; b < NBYTES; b++) begin : g_lane
      assign dout[8*b +: 8] = rev ? din[8*(NBYTES-1-b) +: 8] : din[8*b +: 8];
    end
  endgenerate
endmodule

// File: rtl/hp_fifo.sv
module hp_fifo #(
  parameter int unsigned W     = 32,
  parameter int unsigned DEPTH = 4,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [W-1:0]     din,
  input  logic             pop,
  output logic [W-1:0]     dout,
  output logic             full,
  output logic             empty,
  output logic [CNT_W-1:0] count
);
  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wptr_q, wptr_d, rptr_q, rptr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             push_ok, pop_ok;

  assign full    = (cnt_q == CNT_W'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    wptr_d = push_ok ? bump(wptr_q) : wptr_q;
    rptr_d = pop_ok  ? bump(rptr_q) : rptr_q;
    cnt_d  = cnt_q;
    if (push_ok && !pop_ok)      cnt_d = cnt_q + 1'b1;
    else if (pop_ok && !push_ok) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      cnt_q  <= cnt_d;
    end

  always_ff @(posedge clk)
    if (push_ok) mem[wptr_q] <= din;

  assign dout  = empty ? '0 : mem[rptr_q];
  assign count = cnt_q;

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH)); // R9
  AST_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |=> $stable(cnt_q)); // R9
  AST_POP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !empty && !push) |=> (cnt_q == $past(cnt_q) - CNT_W'(1))); // R8
endmodule

// File: rtl/hostport_bridge.sv
module hostport_bridge
  import hp_pkg::*;
#(
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned FIFO_DEPTH  = 4,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned CNT_W = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hcs_n,
  input  logic              hrd_n,
  input  logic              hwr_n,
  input  logic [ADDR_W-1:0] haddr,
  input  logic [31:0]       hwdata,
  input  logic              hbig_end,
  input  logic              hfifo_sel,
  output logic [31:0]       hrdata,
  output logic              hrd_oe,
  output logic              irq,
  input  logic              rx_push,
  input  logic [31:0]       rx_wdata,
  output logic              rx_full,
  input  logic              tx_pop,
  output logic [31:0]       tx_rdata,
  output logic              tx_empty
);
  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sh_q;
  logic       rst_i;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) rst_sh_q <= '0;
    else        rst_sh_q <= {rst_sh_q[0], 1'b1};
  assign rst_i = rst_sh_q[1];

  // strobe synchronizer
  logic [2:0] strb_s;
  logic       cs_s, rd_s, wr_s;
  hp_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_i), .din({~hcs_n, ~hrd_n, ~hwr_n}), .dout(strb_s));
  assign {cs_s, rd_s, wr_s} = strb_s;

  logic rd_act, wr_act, rd_act_q, wr_act_q;
  logic rd_start, rd_end, commit;
  assign rd_act   = cs_s && rd_s;
  assign wr_act   = cs_s && wr_s;
  assign rd_start = rd_act && !rd_act_q;
  assign rd_end   = rd_act_q && !rd_act;
  assign commit   = wr_act_q && !wr_act;

  // byte lanes at the host edge
  logic [31:0] wdata_le, rraw, rdata_host;
  hp_swap #(.NBYTES(BYTES)) u_wswap (.rev(hbig_end), .din(hwdata), .dout(wdata_le));
  hp_swap #(.NBYTES(BYTES)) u_rswap (.rev(hbig_end), .din(rraw),   .dout(rdata_host));

  tgt_e live_tgt;
  assign live_tgt = hfifo_sel ? TGT_TX : map_addr(32'(haddr));

  // state
  tgt_e            wtgt_q, wtgt_d, rtgt;
  logic [31:0]     wdat_q, wdat_d, scr_q, scr_d, rdat_q, rdat_d;
  logic [NEVT-1:0] sts_q, sts_d, en_q, en_d, evt_set, evt_clr;
  logic            oe_q, oe_d, pend_q, pend_d, irq_q, irq_d;

  // FIFOs
  logic [31:0]      rx_head;
  logic [CNT_W-1:0] tx_cnt, rx_cnt;
  logic             tx_full, rx_empty, tx_push, rx_pop;
  logic             ovf_ev, unf_ev, arr_ev;

  assign tx_push = commit && (wtgt_q == TGT_TX);
  assign rx_pop  = rd_end && pend_q;

  hp_fifo #(.W(32), .DEPTH(FIFO_DEPTH)) u_txf (
    .clk(clk), .rst_n(rst_i), .push(tx_push), .din(wdat_q), .pop(tx_pop),
    .dout(tx_rdata), .full(tx_full), .empty(tx_empty), .count(tx_cnt));
  hp_fifo #(.W(32), .DEPTH(FIFO_DEPTH)) u_rxf (
    .clk(clk), .rst_n(rst_i), .push(rx_push), .din(rx_wdata), .pop(rx_pop),
    .dout(rx_head), .full(rx_full), .empty(rx_empty), .count(rx_cnt));

  // read source
  assign rtgt = hfifo_sel ? TGT_RX : map_addr(32'(haddr));
  always_comb begin
    case (rtgt)
      TGT_RX:  rraw = rx_head;
      TGT_LVL: rraw = {16'h0, 8'(tx_cnt), 8'(rx_cnt)};
      TGT_STS: rraw = 32'(sts_q);
      TGT_EN:  rraw = 32'(en_q);
      TGT_SCR: rraw = scr_q;
      default: rraw = '0;
    endcase
  end

  assign ovf_ev  = tx_push && tx_full;
  assign unf_ev  = rd_start && (rtgt == TGT_RX) && rx_empty;
  assign arr_ev  = rx_push && !rx_full;
  assign evt_set = {arr_ev, unf_ev, ovf_ev};
  assign evt_clr = (commit && wtgt_q == TGT_STS) ? wdat_q[NEVT-1:0] : '0;

  always_comb begin
    wtgt_d = wr_act ? live_tgt : wtgt_q;
    wdat_d = wr_act ? wdata_le : wdat_q;
    scr_d  = (commit && wtgt_q == TGT_SCR) ? wdat_q : scr_q;
    en_d   = (commit && wtgt_q == TGT_EN) ? wdat_q[NEVT-1:0] : en_q;
    sts_d  = (sts_q & ~evt_clr) | evt_set;
    rdat_d = rd_start ? rdata_host : rdat_q;
    oe_d   = rd_start || (rd_act && oe_q);
    pend_d = rd_start ? (rtgt == TGT_RX && !rx_empty) : (rd_end ? 1'b0 : pend_q);
    irq_d  = |(sts_q & en_q);
  end

  always_ff @(posedge clk or negedge rst_i)
    if (!rst_i) begin
      rd_act_q <= 1'b0;
      wr_act_q <= 1'b0;
      wtgt_q   <= TGT_NONE;
      wdat_q   <= '0;
      scr_q    <= '0;
      en_q     <= '0;
      sts_q    <= '0;
      rdat_q   <= '0;
      oe_q     <= 1'b0;
      pend_q   <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      rd_act_q <= rd_act;
      wr_act_q <= wr_act;
      wtgt_q   <= wtgt_d;
      wdat_q   <= wdat_d;
      scr_q    <= scr_d;
      en_q     <= en_d;
      sts_q    <= sts_d;
      rdat_q   <= rdat_d;
      oe_q     <= oe_d;
      pend_q   <= pend_d;
      irq_q    <= irq_d;
    end

  assign hrd_oe = oe_q;
  assign hrdata = oe_q ? rdat_q : '0;
  assign irq    = irq_q;

  AST_ONE_COMMIT: assert property (@(posedge clk) disable iff (!rst_i)
    commit |=> !commit); // R2
  AST_OE_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_i)
    oe_q |-> $past(rd_act)); // R3
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_i)
    ovf_ev |=> sts_q[0]); // R9
  AST_UNF_STICKY: assert property (@(posedge clk) disable iff (!rst_i)
    unf_ev |=> sts_q[1]); // R10
  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_i)
    $rose(irq_q) |-> $past(|en_q)); // R12
endmodule

// File: tb/hostport_bridge_test.sv
module hostport_bridge_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        hcs_n, hrd_n, hwr_n, hbig_end, hfifo_sel;
  logic [7:0]  haddr;
  logic [31:0] hwdata, hrdata, rx_wdata, tx_rdata;
  logic        hrd_oe, irq, rx_push, rx_full, tx_pop, tx_empty;

  always #4 clk = ~clk;

  hostport_bridge #(.ADDR_W(8), .FIFO_DEPTH(4), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst_n(rst_n), .hcs_n(hcs_n), .hrd_n(hrd_n), .hwr_n(hwr_n),
    .haddr(haddr), .hwdata(hwdata), .hbig_end(hbig_end), .hfifo_sel(hfifo_sel),
    .hrdata(hrdata), .hrd_oe(hrd_oe), .irq(irq), .rx_push(rx_push),
    .rx_wdata(rx_wdata), .rx_full(rx_full), .tx_pop(tx_pop),
    .tx_rdata(tx_rdata), .tx_empty(tx_empty));

  int nvec = 0;
  int nbad = 0;
  logic finished = 1'b0;

  function automatic logic [31:0] rev4(input logic [31:0] d);
    return {d[7:0], d[15:8], d[23:16], d[31:24]};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hwrite(input logic [7:0] a, input logic [31:0] d, input logic be, input logic fs);
    @(negedge clk);
    haddr = a; hwdata = d; hbig_end = be; hfifo_sel = fs;
    hcs_n = 1'b0; hwr_n = 1'b0;
    repeat (4) @(negedge clk);
    hcs_n = 1'b1; hwr_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic hread(input logic [7:0] a, input logic be, input logic fs,
                       output logic [31:0] d, output logic oe_on, output logic [31:0] after);
    @(negedge clk);
    haddr = a; hbig_end = be; hfifo_sel = fs;
    hcs_n = 1'b0; hrd_n = 1'b0;
    repeat (5) @(negedge clk);
    d = hrdata; oe_on = hrd_oe;
    hcs_n = 1'b1; hrd_n = 1'b1;
    repeat (4) @(negedge clk);
    after = {hrdata[31:1], hrdata[0] | hrd_oe};
  endtask

  task automatic rxput(input logic [31:0] d);
    @(negedge clk); rx_push = 1'b1; rx_wdata = d;
    @(negedge clk); rx_push = 1'b0;
  endtask

  task automatic txtake;
    @(negedge clk); tx_pop = 1'b1;
    @(negedge clk); tx_pop = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nbad++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd, aft, scr_exp, stored;
    logic        oe;
    logic [31:0] pats [4];
    pats[0] = 32'h0123_4567; pats[1] = 32'hA5C3_0F81;
    pats[2] = 32'hFFFF_0000; pats[3] = 32'h8000_0001;

    rst_n = 1'b0; hcs_n = 1'b1; hrd_n = 1'b1; hwr_n = 1'b1;
    haddr = '0; hwdata = '0; hbig_end = 1'b0; hfifo_sel = 1'b0;
    rx_push = 1'b0; rx_wdata = '0; tx_pop = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check("R1 oe", 32'(hrd_oe), 0);
    check("R1 rdata", hrdata, 0);
    check("R1 irq", 32'(irq), 0);
    check("R1 tx_empty", 32'(tx_empty), 1);
    check("R1 rx_full", 32'(rx_full), 0);
    hread(8'h08, 1'b0, 1'b0, rd, oe, aft); check("R1 level", rd, 0);
    hread(8'h0C, 1'b0, 1'b0, rd, oe, aft); check("R1 status", rd, 0);
    hread(8'h10, 1'b0, 1'b0, rd, oe, aft); check("R1 enable", rd, 0);
    hread(8'h14, 1'b0, 1'b0, rd, oe, aft); check("R1 scratch", rd, 0);

    // R4 / R5 sweep over patterns and both byte orders
    scr_exp = '0;
    foreach (pats[p]) begin
      for (int wb = 0; wb < 2; wb++) begin
        for (int rb = 0; rb < 2; rb++) begin
          hwrite(8'h14, pats[p], wb[0], 1'b0);
          stored = wb[0] ? rev4(pats[p]) : pats[p];
          scr_exp = stored;
          hread(8'h14, rb[0], 1'b0, rd, oe, aft);
          if (wb == 0 && rb == 0) check("R4 passthrough", rd, stored);
          else check("R5 byte order", rd, rb[0] ? rev4(stored) : stored);
          check("R3 oe during read", 32'(oe), 1);
          check("R3 released", aft, 0);
        end
      end
    end

    // R6 unmapped and misaligned addresses
    hwrite(8'h20, 32'h5555_AAAA, 1'b0, 1'b0);
    hread(8'h20, 1'b0, 1'b0, rd, oe, aft); check("R6 unmapped reads zero", rd, 0);
    hwrite(8'h15, 32'h1357_9BDF, 1'b0, 1'b0);
    hread(8'h15, 1'b0, 1'b0, rd, oe, aft); check("R6 misaligned reads zero", rd, 0);
    hread(8'h14, 1'b0, 1'b0, rd, oe, aft); check("R6 scratch untouched", rd, scr_exp);
    hread(8'h04, 1'b0, 1'b0, rd, oe, aft); check("R10 empty rx reads zero", rd, 0);
    hread(8'h0C, 1'b0, 1'b0, rd, oe, aft); check("R10 underflow bit", rd, 32'h2);
    hwrite(8'h0C, 32'h2, 1'b0, 1'b0);
    hread(8'h0C, 1'b0, 1'b0, rd, oe, aft); check("R11 w1c clears", rd, 0);

    // R2 / R7 / R9 transmit path
    hwrite(8'h00, 32'h1122_3344, 1'b0, 1'b0);
    check("R2 tx not empty", 32'(tx_empty), 0);
    hread(8'h08, 1'b0, 1'b0, rd, oe, aft); check("R2 one push per write", rd, 32'h0100);
    hwrite(8'h14, 32'hAABB_CCDD, 1'b1, 1'b1);
    hread(8'h08, 1'b0, 1'b0, rd, oe, aft); check("R7 steered write", rd, 32'h0200);
    hread(8'h14, 1'b0, 1'b0, rd, oe, aft); check("R7 scratch unchanged", rd, scr_exp);
    hwrite(8'h30, 32'h0000_00FF, 1'b0, 1'b1);
    hwrite(8'h00, 32'hDEAD_BEEF, 1'b0, 1'b0);
    hread(8'h0C, 1'b0, 1'b0, rd, oe, aft); check("R9 no overflow yet", rd, 0);
    hwrite(8'h00, 32'h1234_5678, 1'b0, 1'b0);
    hread(8'h08, 1'b0, 1'b0, rd, oe, aft); check("R9 full count held", rd, 32'h0400);
    hread(8'h0C, 1'b0, 1'b0, rd, oe, aft); check("R9 overflow bit", rd, 32'h1);
    check("R12 irq masked", 32'(irq), 0);
    check("R7 tx head 0", tx_rdata, 32'h1122_3344); txtake;
    check("R5 tx head 1 reversed", tx_rdata, 32'hDDCC_BBAA); txtake;
    check("R7 tx head 2", tx_rdata, 32'h0000_00FF); txtake;
    check("R9 tx head 3 not overwritten", tx_rdata, 32'hDEAD_BEEF); txtake;
    check("R9 tx drained", 32'(tx_empty), 1);

    // R8 / R10 / R11 receive path
    rxput(32'hCAFE_0001); rxput(32'h0102_0304); rxput(32'h89AB_CDEF);
    hread(8'h0C, 1'b0, 1'b0, rd, oe, aft); check("R11 arrival bit", rd, 32'h5);
    hread(8'h14, 1'b0, 1'b1, rd, oe, aft); check("R8 first word", rd, 32'hCAFE_0001);
    hread(8'h08, 1'b0, 1'b0, rd, oe, aft); check("R8 one pop", rd, 32'h0002);
    hread(8'h04, 1'b1, 1'b0, rd, oe, aft); check("R8 second word reversed", rd, 32'h0403_0201);
    hread(8'h10, 1'b0, 1'b1, rd, oe, aft); check("R7 steered read", rd, 32'h89AB_CDEF);
    hread(8'h08, 1'b0, 1'b0, rd, oe, aft); check("R8 rx empty", rd, 0);
    hread(8'h3C, 1'b0, 1'b1, rd, oe, aft); check("R10 underflow zero", rd, 0);
    hread(8'h0C, 1'b0, 1'b0, rd, oe, aft); check("R10 status", rd, 32'h7);

    // R12 interrupt and R11 clear
    check("R12 irq off", 32'(irq), 0);
    hwrite(8'h10, 32'h2, 1'b0, 1'b0);
    check("R12 irq on", 32'(irq), 1);
    hread(8'h10, 1'b0, 1'b0, rd, oe, aft); check("R6 enable readback", rd, 32'h2);
    hwrite(8'h0C, 32'h5, 1'b0, 1'b0);
    check("R12 irq stays", 32'(irq), 1);
    hread(8'h0C, 1'b0, 1'b0, rd, oe, aft); check("R11 partial clear", rd, 32'h2);
    hwrite(8'h0C, 32'h0200_0000, 1'b1, 1'b0);
    check("R12 irq off after clear", 32'(irq), 0);
    hread(8'h0C, 1'b0, 1'b0, rd, oe, aft); check("R11 big-endian clear", rd, 0);

    finished = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule